// File: doc/BRIEF.md
# Mailbox Message Packer

This block sends one message into a mailbox whose write side is a single 32-bit window. A message is a 32-bit header plus a payload of bytes. The payload length sits in a 9-bit field in the top bits of the header. When the packer is told to start, it first checks whether the whole message fits in the free slots the mailbox reports. A message that does not fit is refused before any word is written.

A message that fits is written in order. The header word goes first, then the payload bytes packed four to a word with the lowest byte in the lowest lane. A trailing partial word has zero in its unused upper lanes. The payload bytes arrive on a valid/ready byte stream, and the packer takes exactly as many bytes as the length field says. After the last word it writes the mailbox control register once to ring the doorbell. That write sets the interrupt-generate bit and forces the write-one-to-clear status bit to zero.

One cycle after the doorbell, the packer samples the far side's ready line. It then ends the message with a one-cycle done pulse and a status code.

Top module: `mbx_msg_packer`

## Requirements
- R1: After reset, busy, done, wr_en, csr_we and s_ready are all low.
- R2: When start is accepted while idle and the message fits, the next cycle writes one word equal to hdr_in through wr_en/wr_data, before any payload word.
- R3: Payload bytes are packed little-endian: byte n of the payload is placed in bits [8*(n mod 4)+7 : 8*(n mod 4)] of payload word n/4.
- R4: When the length is not a multiple of 4, the last payload word carries the remaining bytes in its low lanes and zero in every other lane.
- R5: The payload length is hdr_in[31:23]. The packer accepts exactly that many bytes from the stream and holds s_ready low at all other times.
- R6: A message needs 1 + ceil(length/4) slots. If free_slots (8-bit two's complement) is negative or smaller than that, the packer writes no word, rings no doorbell and takes no byte. It ends with status 1 (no space).
- R7: One cycle after the last word of an accepted message, csr_we pulses once. csr_wdata equals csr_q with bit 2 (interrupt generate) set and bit 1 (write-one-to-clear status) cleared, and every other bit unchanged.
- R8: Every accepted start ends with done high for exactly one cycle. In that cycle status is 0 (ok) if peer_ready was high in the cycle after the doorbell, 2 (not ready) if it was low, or 1 (no space) on refusal.
- R9: start is ignored while busy is high, including the cycle in which done is high.
- R10: Gaps in s_valid delay the message but change neither the words written nor their order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a message (accepted only while idle) |
| hdr_in | input | 32 | Message header; bits 31:23 hold the payload length |
| free_slots | input | 8 | Signed count of free mailbox slots |
| peer_ready | input | 1 | Far side ready indication |
| csr_q | input | 32 | Current value of the mailbox control register |
| s_valid | input | 1 | Payload byte valid |
| s_data | input | 8 | Payload byte |
| s_ready | output | 1 | Payload byte accepted when high with s_valid |
| wr_en | output | 1 | Window write strobe |
| wr_data | output | 32 | Window write data |
| csr_we | output | 1 | Control register write strobe (doorbell) |
| csr_wdata | output | 32 | Control register write data |
| busy | output | 1 | A message is in progress |
| done | output | 1 | One-cycle end-of-message pulse |
| status | output | 2 | Result code, valid while done is high |

## Verification
Two events can fall in the same cycle: the end-of-message done pulse and a new start pulse. The bench raises start in exactly the cycle where done is high, and again in the middle of a payload. It then checks that no header write follows, that done appears only once, and that the packer is idle afterwards. A second case is a byte handshake that also completes a word. Here the word write and the byte acceptance share a cycle. Payload checks run with and without stream gaps and compare every word.

// File: rtl/mbx_pack_pkg.sv
package mbx_pack_pkg;
  typedef enum logic [1:0] {
    ST_OK       = 2'd0,
    ST_NO_SPACE = 2'd1,
    ST_NOT_RDY  = 2'd2
  } pack_status_e;

  typedef enum logic [2:0] {
    PK_IDLE,
    PK_HDR,
    PK_PAY,
    PK_RING,
    PK_CHK,
    PK_DONE
  } pack_state_e;
endpackage

// File: rtl/mbx_fit_check.sv
module mbx_fit_check #(
  parameter int LEN_W  = 9,
  parameter int SLOT_W = 8,
  parameter int WB     = 4
) (
  input  logic [LEN_W-1:0]  len_i,
  input  logic [SLOT_W-1:0] free_i,
  output logic              fits_o
);
  localparam int WW = (LEN_W > SLOT_W ? LEN_W : SLOT_W) + 1;

  logic [WW-1:0] need;
  logic [WW-1:0] free_ext;

  always_comb begin
    need     = WW'(1) + ((WW'(len_i) + WW'(WB - 1)) / WW'(WB));
    free_ext = WW'(free_i);
    fits_o   = !free_i[SLOT_W-1] && (need <= free_ext);
  end
endmodule

// File: rtl/mbx_lane_packer.sv
module mbx_lane_packer #(
  parameter int WB = 4,
  localparam int LW = (WB > 1) ? $clog2(WB) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take_i,
  input  logic            last_i,
  input  logic [7:0]      byte_i,
  output logic [8*WB-1:0] word_o,
  output logic            fire_o
);
  logic [LW-1:0] lane_q, lane_d;
  logic [7:0]    acc_q [WB-1];
  logic [7:0]    acc_d [WB-1];

  assign fire_o = take_i && ((lane_q == LW'(WB - 1)) || last_i);

  for (genvar k = 0; k < WB; k++) begin : g_lane
    if (k < WB - 1) begin : g_held
      assign word_o[8*k +: 8] = (LW'(k) < lane_q) ? acc_q[k]
                              : ((LW'(k) == lane_q) ? byte_i : 8'h00);
    end else begin : g_top
      assign word_o[8*k +: 8] = (LW'(k) == lane_q) ? byte_i : 8'h00;
    end
  end

  always_comb begin
    lane_d = lane_q;
    for (int k = 0; k < WB - 1; k++) acc_d[k] = acc_q[k];
    if (take_i) begin
      if (fire_o) lane_d = '0;
      else        lane_d = lane_q + LW'(1);
      for (int k = 0; k < WB - 1; k++)
        if (LW'(k) == lane_q) acc_d[k] = byte_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_q <= '0;
      for (int k = 0; k < WB - 1; k++) acc_q[k] <= 8'h00;
    end else if (take_i) begin
      lane_q <= lane_d;
      for (int k = 0; k < WB - 1; k++) acc_q[k] <= acc_d[k];
    end
  end
endmodule

// File: rtl/mbx_msg_packer.sv
module mbx_msg_packer #(
  parameter int LEN_W  = 9,
  parameter int SLOT_W = 8,
  parameter int IG_BIT = 2,
  parameter int IS_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       hdr_in,
  input  logic [SLOT_W-1:0] free_slots,
  input  logic              peer_ready,
  input  logic [31:0]       csr_q,
  input  logic              s_valid,
  input  logic [7:0]        s_data,
  output logic              s_ready,
  output logic              wr_en,
  output logic [31:0]       wr_data,
  output logic              csr_we,
  output logic [31:0]       csr_wdata,
  output logic              busy,
  output logic              done,
  output logic [1:0]        status
);
  import mbx_pack_pkg::*;

  localparam int WB     = 4;
  localparam int LEN_LO = 32 - LEN_W;

  pack_state_e  st_q, st_d;
  pack_status_e stat_q, stat_d;
  logic [31:0]      hdr_q, hdr_d;
  logic [LEN_W-1:0] left_q, left_d;

  logic [LEN_W-1:0] len_in;
  logic             fits;
  logic             take;
  logic             last_byte;
  logic [31:0]      packed_word;
  logic             word_fire;

  assign len_in = hdr_in[31:LEN_LO];

  mbx_fit_check #(.LEN_W(LEN_W), .SLOT_W(SLOT_W), .WB(WB)) i_fit (
    .len_i  (len_in),
    .free_i (free_slots),
    .fits_o (fits)
  );

  assign s_ready   = (st_q == PK_PAY);
  assign take      = s_ready && s_valid;
  assign last_byte = (left_q == LEN_W'(1));

  mbx_lane_packer #(.WB(WB)) i_lanes (
    .clk    (clk),
    .rst_n  (rst_n),
    .take_i (take),
    .last_i (last_byte),
    .byte_i (s_data),
    .word_o (packed_word),
    .fire_o (word_fire)
  );

  always_comb begin
    st_d   = st_q;
    stat_d = stat_q;
    hdr_d  = hdr_q;
    left_d = left_q;
    unique case (st_q)
      PK_IDLE: begin
        if (start) begin
          hdr_d  = hdr_in;
          left_d = len_in;
          if (fits) begin
            st_d = PK_HDR;
          end else begin
            stat_d = ST_NO_SPACE;
            st_d   = PK_DONE;
          end
        end
      end
      PK_HDR:  st_d = (left_q == '0) ? PK_RING : PK_PAY;
      PK_PAY: begin
        if (take) begin
          left_d = left_q - LEN_W'(1);
          if (last_byte) st_d = PK_RING;
        end
      end
      PK_RING: st_d = PK_CHK;
      PK_CHK: begin
        stat_d = peer_ready ? ST_OK : ST_NOT_RDY;
        st_d   = PK_DONE;
      end
      PK_DONE: st_d = PK_IDLE;
      default: st_d = PK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PK_IDLE;
      stat_q <= ST_OK;
      hdr_q  <= '0;
      left_q <= '0;
    end else begin
      st_q   <= st_d;
      stat_q <= stat_d;
      hdr_q  <= hdr_d;
      left_q <= left_d;
    end
  end

  always_comb begin
    wr_en     = (st_q == PK_HDR) || word_fire;
    wr_data   = (st_q == PK_HDR) ? hdr_q : packed_word;
    csr_we    = (st_q == PK_RING);
    csr_wdata = csr_q;
    csr_wdata[IG_BIT] = 1'b1;
    csr_wdata[IS_BIT] = 1'b0;
    busy      = (st_q != PK_IDLE);
    done      = (st_q == PK_DONE);
    status    = stat_q;
  end
endmodule

// File: rtl/mbx_msg_packer_chk.sv
module mbx_msg_packer_chk #(
  parameter int LEN_W  = 9,
  parameter int SLOT_W = 8,
  parameter int IG_BIT = 2,
  parameter int IS_BIT = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [31:0]       hdr_in,
  input logic [SLOT_W-1:0] free_slots,
  input logic              peer_ready,
  input logic [31:0]       csr_q,
  input logic              s_valid,
  input logic [7:0]        s_data,
  input logic              s_ready,
  input logic              wr_en,
  input logic [31:0]       wr_data,
  input logic              csr_we,
  input logic [31:0]       csr_wdata,
  input logic              busy,
  input logic              done,
  input logic [1:0]        status
);
  // R2: accepted start leads to a header write or an immediate refusal
  a_r2_hdr_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (wr_en || done));

  // R5: bytes are only taken while a message is in progress
  a_r5_ready_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> busy);

  // R6: a refusal is never preceded by a window write
  a_r6_no_write_on_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == 2'd1) |-> $past(!wr_en && !csr_we));

  // R7: doorbell is a single pulse and nothing is written right after it
  a_r7_db_single: assert property (@(posedge clk) disable iff (!rst_n)
    csr_we |=> (!csr_we && !wr_en && busy));

  // R8: done lasts one cycle and carries a defined code
  a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_status_code: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (status != 2'd3));

  // R9: a start during done does not restart the packer
  a_r9_start_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

bind mbx_msg_packer mbx_msg_packer_chk #(
  .LEN_W(LEN_W), .SLOT_W(SLOT_W), .IG_BIT(IG_BIT), .IS_BIT(IS_BIT)
) i_chk (.*);

// File: tb/test_mbx_msg_packer.sv
module test_mbx_msg_packer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [31:0] hdr_in;
  logic [7:0]  free_slots;
  logic        peer_ready;
  logic [31:0] csr_q;
  logic        s_valid;
  logic [7:0]  s_data;
  logic        s_ready, wr_en, csr_we, busy, done;
  logic [31:0] wr_data, csr_wdata;
  logic [1:0]  status;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  mbx_msg_packer i_mbx_msg_packer (
    .clk(clk), .rst_n(rst_n), .start(start), .hdr_in(hdr_in),
    .free_slots(free_slots), .peer_ready(peer_ready), .csr_q(csr_q),
    .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .wr_en(wr_en), .wr_data(wr_data), .csr_we(csr_we),
    .csr_wdata(csr_wdata), .busy(busy), .done(done), .status(status)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int i, input int v);
    return 8'(i * 13 + v * 29 + 5);
  endfunction

  // vector: {len[9], free[8], peer_ready, stall, exp_status[2]}
  localparam int NV = 10;
  localparam logic [20:0] VEC [NV] = '{
    {9'd0,   8'd1,   1'b1, 1'b0, 2'd0},
    {9'd4,   8'd2,   1'b1, 1'b0, 2'd0},
    {9'd5,   8'd3,   1'b1, 1'b0, 2'd0},
    {9'd7,   8'd3,   1'b1, 1'b1, 2'd0},
    {9'd6,   8'd2,   1'b1, 1'b0, 2'd1},
    {9'd8,   8'hFF,  1'b1, 1'b0, 2'd1},
    {9'd3,   8'd2,   1'b0, 1'b0, 2'd2},
    {9'd124, 8'd32,  1'b1, 1'b0, 2'd0},
    {9'd125, 8'd32,  1'b1, 1'b0, 2'd1},
    {9'd2,   8'd127, 1'b1, 1'b1, 2'd0}
  };

  task automatic run_msg(input int v, input int len, input logic [7:0] free,
                         input logic rdy, input logic stall, input logic [1:0] exp_st,
                         input logic [31:0] cq, input logic poke_busy);
    logic [31:0] words [0:199];
    int nw = 0, idx = 0, ndb = 0, ndone = 0, cyc = 0, bad_w = 0;
    logic [31:0] db_data = '0;
    logic [1:0]  got_st = '0;
    logic [31:0] hdr;
    logic [31:0] expw;
    int expn;
    hdr = {9'(len), 23'(v * 4099 + 17)};
    @(negedge clk);
    start = 1'b1; hdr_in = hdr; free_slots = free; peer_ready = rdy; csr_q = cq;
    s_valid = 1'b0;
    while (ndone == 0 && cyc < 400) begin
      @(negedge clk);
      start = 1'b0;
      if (poke_busy && cyc == 3) begin start = 1'b1; hdr_in = 32'h0100_0000; end
      s_valid = (idx < len) && !(stall && (cyc % 3 == 1));
      s_data  = pat(idx, v);
      #1;
      if (wr_en && nw < 200) begin words[nw] = wr_data; nw++; end
      if (csr_we) begin ndb++; db_data = csr_wdata; end
      if (s_valid && s_ready) idx++;
      if (done) begin
        ndone++; got_st = status;
        start = 1'b1; hdr_in = 32'h0080_0000; free_slots = 8'd100; // R9: start on done
      end
      cyc++;
    end
    @(negedge clk);
    start = 1'b0;
    #1;
    check($sformatf("R9 idle after done v%0d", v), {30'd0, busy, wr_en}, 32'd0);
    @(negedge clk);
    #1;
    check($sformatf("R9 no restart v%0d", v), {31'd0, wr_en}, 32'd0);
    check($sformatf("R8 status v%0d", v), 32'(got_st), 32'(exp_st));
    check($sformatf("R8 done count v%0d", v), 32'(ndone), 32'd1);
    if (exp_st == 2'd1) begin
      check($sformatf("R6 no words v%0d", v), 32'(nw), 32'd0);
      check($sformatf("R6 no bytes v%0d", v), 32'(idx), 32'd0);
      check($sformatf("R6 no doorbell v%0d", v), 32'(ndb), 32'd0);
    end else begin
      expn = 1 + (len + 3) / 4;
      check($sformatf("R5 bytes taken v%0d", v), 32'(idx), 32'(len));
      check($sformatf("R2 word count v%0d", v), 32'(nw), 32'(expn));
      if (nw > 0) check($sformatf("R2 header v%0d", v), words[0], hdr);
      for (int j = 1; j < nw && j < expn; j++) begin
        expw = '0;
        for (int k = 0; k < 4; k++)
          if (4 * (j - 1) + k < len) expw[8*k +: 8] = pat(4 * (j - 1) + k, v);
        if (words[j] !== expw) begin
          bad_w++;
          $display("FAIL R3/R4/R10 v%0d word%0d actual=0x%08h expected=0x%08h",
                   v, j, words[j], expw);
        end
      end
      n_chk++;
      if (bad_w != 0) n_bad++;
      check($sformatf("R7 doorbell count v%0d", v), 32'(ndb), 32'd1);
      check($sformatf("R7 doorbell data v%0d", v), db_data, (cq | 32'h4) & ~32'h2);
    end
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; hdr_in = '0; free_slots = '0; peer_ready = 1'b0;
    csr_q = '0; s_valid = 1'b0; s_data = '0;
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset outputs", {27'd0, busy, done, wr_en, csr_we, s_ready}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check("R1 idle after release", {27'd0, busy, done, wr_en, csr_we, s_ready}, 32'd0);

    for (int v = 0; v < NV; v++)
      run_msg(v, int'(VEC[v][20:12]), VEC[v][11:4], VEC[v][3], VEC[v][2], VEC[v][1:0],
              32'h0000_0F0A ^ 32'(v << 8), 1'b0);

    // R9: start mid-message; R7 with all control bits set
    run_msg(20, 9, 8'd4, 1'b1, 1'b0, 2'd0, 32'hFFFF_FFFF, 1'b1);
    // R10 + R4: long stalled partial message
    run_msg(21, 11, 8'd4, 1'b1, 1'b1, 2'd0, 32'h0000_0000, 1'b0);
    // R6 boundary: exactly one slot short, with status bits set
    run_msg(22, 12, 8'd3, 1'b1, 1'b0, 2'd1, 32'h0000_0002, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule